// File: doc/BRIEF.md
# Integer execute unit

A purely combinational execute stage for a 32-bit load/store RISC core. It receives one 32-bit instruction word together with the values already read from the two source registers. In the same cycle it returns the value to write back, the index of the destination register, a write strobe and a signed-overflow status bit. Register-format words carry a 6-bit function code that selects add, subtract, compare, logical or shift work. Immediate-format words carry a 16-bit constant, which is extended according to the class of the operation.

The surrounding pipeline supplies the operand values and commits the result to the register file when the write strobe is high. Overflow is reported only. It never suppresses the write, and it never raises a trap. Words that this unit does not implement drop the write strobe, so the pipeline can route them elsewhere. A write aimed at register 0 is also suppressed, because that register always reads as zero.

Top module: `exu_top`

## Requirements
- R1: Fields are op = bits 31:26, rs = 25:21, rt = 20:16, rd = 15:11, shamt = 10:6, func = 5:0 and imm = 15:0. With op 0x00, func 0x20 (add) and 0x21 (addu) give rs_val + rt_val, and func 0x22 (sub) and 0x23 (subu) give rs_val - rt_val, all modulo 2^32.
- R2: With op 0x00, func 0x24, 0x25, 0x26 and 0x27 give the bitwise AND, OR, XOR and NOR of rs_val and rt_val.
- R3: With op 0x00, func 0x2A (signed) and func 0x2B (unsigned) return 1 when rs_val < rt_val and 0 otherwise. Bits 31:1 of the result are zero.
- R4: func 0x00, 0x02 and 0x03 shift rt_val by the shamt field: left, right with zero fill, and right with copies of the sign bit. The rs field must be zero; any other value makes the word undefined.
- R5: func 0x04, 0x06 and 0x07 shift rt_val left, logical right and arithmetic right by rs_val[4:0]. Bits 31:5 of rs_val are ignored.
- R6: op 0x08 (addi) and 0x09 (addiu) add the sign-extended imm to rs_val. op 0x0A and 0x0B compare rs_val with the sign-extended imm, signed and unsigned respectively, and return 1 or 0.
- R7: op 0x0C, 0x0D and 0x0E give the AND, OR and XOR of rs_val with the zero-extended imm.
- R8: op 0x0F returns imm in bits 31:16, with zeros in bits 15:0.
- R9: dest_o is the rd field for register-format words and the rt field for immediate-format words.
- R10: ovf_o is 1 exactly when add, sub or addi overflows as a signed operation. The wrapped result is still written. addu, subu and addiu never set it.
- R11: Every op or func code not listed above, and every fixed shift with a nonzero rs field, gives wr_en_o = 0, ovf_o = 0 and result_o = 0.
- R12: wr_en_o is 0 whenever the destination index is 0. The result and ovf_o are still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of register rs |
| rt_val_i | input | 32 | Value of register rt |
| result_o | output | 32 | Write-back value |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write strobe |
| ovf_o | output | 1 | Signed overflow status |

## Verification
The overflow flag and the write strobe can be active on the same word, and so can the overflow flag and a suppressed write to register 0. The bench provokes the first case with add and addi at the signed limits, for example 0x7FFFFFFF + 1 and 0x80000000 + 0xFFFFFFFF. For those words it expects the wrapped sum, the flag and the strobe all together. The second case uses the same operands with the destination set to 0. There the bench expects the flag with the strobe low, and it expects the unsigned forms to stay unflagged under the same operands.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int ILEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_ADDIU = 6'h09;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_SLTIU = 6'h0B;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_XORI  = 6'h0E;
  localparam logic [5:0] OPC_LUI   = 6'h0F;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SHL, ALU_SHR, ALU_SRA, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_SIGN, IMM_ZERO, IMM_UPPER
  } imm_e;

  typedef struct packed {
    logic    valid;
    alu_op_e alu_op;
    logic    use_imm;
    imm_e    imm_kind;
    logic    var_shift;
    logic    ovf_chk;
    logic    dest_rd;
  } ctrl_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [5:0] opc_i,
  input  logic [5:0] func_i,
  input  logic [4:0] rs_fld_i,
  output ctrl_t      ctrl_o
);
  logic rs_zero;
  assign rs_zero = (rs_fld_i == 5'd0);

  always_comb begin
    ctrl_o = '0;
    if (opc_i == OPC_RTYPE) begin
      ctrl_o.dest_rd = 1'b1;
      ctrl_o.valid   = 1'b1;
      unique case (func_i)
        FN_SLL:  begin ctrl_o.alu_op = ALU_SHL; ctrl_o.valid = rs_zero; end
        FN_SRL:  begin ctrl_o.alu_op = ALU_SHR; ctrl_o.valid = rs_zero; end
        FN_SRA:  begin ctrl_o.alu_op = ALU_SRA; ctrl_o.valid = rs_zero; end
        FN_SLLV: begin ctrl_o.alu_op = ALU_SHL; ctrl_o.var_shift = 1'b1; end
        FN_SRLV: begin ctrl_o.alu_op = ALU_SHR; ctrl_o.var_shift = 1'b1; end
        FN_SRAV: begin ctrl_o.alu_op = ALU_SRA; ctrl_o.var_shift = 1'b1; end
        FN_ADD:  begin ctrl_o.alu_op = ALU_ADD; ctrl_o.ovf_chk = 1'b1; end
        FN_ADDU: ctrl_o.alu_op = ALU_ADD;
        FN_SUB:  begin ctrl_o.alu_op = ALU_SUB; ctrl_o.ovf_chk = 1'b1; end
        FN_SUBU: ctrl_o.alu_op = ALU_SUB;
        FN_AND:  ctrl_o.alu_op = ALU_AND;
        FN_OR:   ctrl_o.alu_op = ALU_OR;
        FN_XOR:  ctrl_o.alu_op = ALU_XOR;
        FN_NOR:  ctrl_o.alu_op = ALU_NOR;
        FN_SLT:  ctrl_o.alu_op = ALU_SLT;
        FN_SLTU: ctrl_o.alu_op = ALU_SLTU;
        default: ctrl_o.valid = 1'b0;
      endcase
    end else begin
      ctrl_o.use_imm = 1'b1;
      ctrl_o.valid   = 1'b1;
      unique case (opc_i)
        OPC_ADDI:  begin ctrl_o.alu_op = ALU_ADD; ctrl_o.ovf_chk = 1'b1; end
        OPC_ADDIU: ctrl_o.alu_op = ALU_ADD;
        OPC_SLTI:  ctrl_o.alu_op = ALU_SLT;
        OPC_SLTIU: ctrl_o.alu_op = ALU_SLTU;
        OPC_ANDI:  begin ctrl_o.alu_op = ALU_AND; ctrl_o.imm_kind = IMM_ZERO; end
        OPC_ORI:   begin ctrl_o.alu_op = ALU_OR;  ctrl_o.imm_kind = IMM_ZERO; end
        OPC_XORI:  begin ctrl_o.alu_op = ALU_XOR; ctrl_o.imm_kind = IMM_ZERO; end
        OPC_LUI:   begin ctrl_o.alu_op = ALU_PASSB; ctrl_o.imm_kind = IMM_UPPER; end
        default:   ctrl_o.valid = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/exu_immext.sv
module exu_immext
  import exu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [15:0]     imm_i,
  input  imm_e            kind_i,
  output logic [XLEN-1:0] ext_o
);
  always_comb begin
    unique case (kind_i)
      IMM_ZERO:  ext_o = XLEN'(imm_i);
      IMM_UPPER: ext_o = XLEN'({imm_i, 16'h0000});
      default:   ext_o = XLEN'($signed(imm_i));
    endcase
  end
endmodule

// File: rtl/exu_shift.sv
module exu_shift
  import exu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SHW-1:0]  amt_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] res_o
);
  logic left;
  logic fill;
  logic [XLEN-1:0] stg [SHW+1];

  assign left   = (op_i == ALU_SHL);
  assign fill   = (op_i == ALU_SRA) & data_i[XLEN-1];
  assign stg[0] = data_i;

  // log2 stages, each moving by a power of two in the selected direction
  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int D = 1 << i;
    assign stg[i+1] = !amt_i[i] ? stg[i] :
                      left      ? {stg[i][XLEN-1-D:0], {D{1'b0}}} :
                                  {{D{fill}}, stg[i][XLEN-1:D]};
  end

  assign res_o = stg[SHW];
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] res_o,
  output logic            ovf_o
);
  logic            sub;
  logic [XLEN-1:0] bx;
  logic [XLEN-1:0] sum;
  logic            carry;
  logic            lt_s;
  logic            lt_u;

  // compares share the subtractor
  assign sub = (op_i == ALU_SUB) | (op_i == ALU_SLT) | (op_i == ALU_SLTU);
  assign bx  = sub ? ~b_i : b_i;
  assign {carry, sum} = {1'b0, a_i} + {1'b0, bx} + {{XLEN{1'b0}}, sub};
  assign ovf_o = (a_i[XLEN-1] == bx[XLEN-1]) & (sum[XLEN-1] != a_i[XLEN-1]);
  assign lt_s  = sum[XLEN-1] ^ ovf_o;
  assign lt_u  = ~carry;

  always_comb begin
    unique case (op_i)
      ALU_ADD, ALU_SUB: res_o = sum;
      ALU_AND:   res_o = a_i & b_i;
      ALU_OR:    res_o = a_i | b_i;
      ALU_XOR:   res_o = a_i ^ b_i;
      ALU_NOR:   res_o = ~(a_i | b_i);
      ALU_SLT:   res_o = {{(XLEN-1){1'b0}}, lt_s};
      ALU_SLTU:  res_o = {{(XLEN-1){1'b0}}, lt_u};
      ALU_PASSB: res_o = b_i;
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/exu_top.sv
module exu_top
  import exu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic [XLEN-1:0] result_o,
  output logic [4:0]      dest_o,
  output logic            wr_en_o,
  output logic            ovf_o
);
  ctrl_t           ctrl;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] alu_res;
  logic [XLEN-1:0] sh_res;
  logic [SHW-1:0]  sh_amt;
  logic            alu_ovf;
  logic            is_shift;

  exu_decode u_dec (
    .opc_i    (instr_i[31:26]),
    .func_i   (instr_i[5:0]),
    .rs_fld_i (instr_i[25:21]),
    .ctrl_o   (ctrl)
  );

  exu_immext #(.XLEN(XLEN)) u_imm (
    .imm_i  (instr_i[15:0]),
    .kind_i (ctrl.imm_kind),
    .ext_o  (imm_ext)
  );

  assign opnd_b = ctrl.use_imm ? imm_ext : rt_val_i;
  assign sh_amt = ctrl.var_shift ? rs_val_i[SHW-1:0] : SHW'(instr_i[10:6]);

  exu_alu #(.XLEN(XLEN)) u_alu (
    .a_i   (rs_val_i),
    .b_i   (opnd_b),
    .op_i  (ctrl.alu_op),
    .res_o (alu_res),
    .ovf_o (alu_ovf)
  );

  exu_shift #(.XLEN(XLEN)) u_sh (
    .data_i (rt_val_i),
    .amt_i  (sh_amt),
    .op_i   (ctrl.alu_op),
    .res_o  (sh_res)
  );

  assign is_shift = (ctrl.alu_op == ALU_SHL) | (ctrl.alu_op == ALU_SHR) |
                    (ctrl.alu_op == ALU_SRA);

  assign dest_o   = ctrl.dest_rd ? instr_i[15:11] : instr_i[20:16];
  assign result_o = !ctrl.valid ? '0 : is_shift ? sh_res : alu_res;
  assign wr_en_o  = ctrl.valid & (dest_o != 5'd0);
  assign ovf_o    = ctrl.valid & ctrl.ovf_chk & alu_ovf;
endmodule

// File: rtl/exu_top_chk.sv
module exu_top_chk
  import exu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic [5:0]      opc_i,
  input logic [5:0]      func_i,
  input logic [4:0]      rd_fld_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] rt_val_i,
  input logic [XLEN-1:0] result_o,
  input logic [4:0]      dest_o,
  input logic            wr_en_o,
  input logic            ovf_o
);
  logic rtype;
  logic is_cmp;
  logic is_vsh;
  logic undef_opc;

  assign rtype     = (opc_i == OPC_RTYPE);
  assign is_cmp    = (rtype && (func_i == FN_SLT || func_i == FN_SLTU)) ||
                     opc_i == OPC_SLTI || opc_i == OPC_SLTIU;
  assign is_vsh    = rtype && (func_i == FN_SLLV || func_i == FN_SRLV || func_i == FN_SRAV);
  assign undef_opc = !rtype && (opc_i < OPC_ADDI || opc_i > OPC_LUI);

  always_comb begin
    // R10
    ovf_src_chk: assert (!ovf_o || opc_i == OPC_ADDI ||
                         (rtype && (func_i == FN_ADD || func_i == FN_SUB)));
    // R10
    if (ovf_o && rtype && func_i == FN_ADD)
      ovf_wrap_chk: assert (result_o == rs_val_i + rt_val_i);
    // R12
    wr_dest_chk: assert (!wr_en_o || dest_o != 5'd0);
    // R9
    if (wr_en_o && rtype)
      rdest_chk: assert (dest_o == rd_fld_i);
    // R3
    if (wr_en_o && is_cmp)
      cmp_bit_chk: assert (result_o[XLEN-1:1] == '0);
    // R11
    if (undef_opc)
      undef_chk: assert (!wr_en_o && !ovf_o && result_o == '0);
    // R5
    if (wr_en_o && is_vsh && rs_val_i[4:0] == 5'd0)
      vshift_zero_chk: assert (result_o == rt_val_i);
  end
endmodule

bind exu_top exu_top_chk #(.XLEN(XLEN)) u_chk (
  .opc_i    (instr_i[31:26]),
  .func_i   (instr_i[5:0]),
  .rd_fld_i (instr_i[15:11]),
  .rs_val_i (rs_val_i),
  .rt_val_i (rt_val_i),
  .result_o (result_o),
  .dest_o   (dest_o),
  .wr_en_o  (wr_en_o),
  .ovf_o    (ovf_o)
);

// File: tb/sim_exu_top.sv
`timescale 1ns/1ps
module sim_exu_top;
  logic        clk = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] result;
  logic [4:0]  dest;
  logic        wr_en;
  logic        ovf;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] seed = 32'h1BADF00D;

  always #10 clk = ~clk;

  exu_top u0 (
    .instr_i  (instr),
    .rs_val_i (rs_val),
    .rt_val_i (rt_val),
    .result_o (result),
    .dest_o   (dest),
    .wr_en_o  (wr_en),
    .ovf_o    (ovf)
  );

  function automatic logic [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic logic [31:0] rw(input logic [4:0] rs, rt, rd, sh, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] iw(input logic [5:0] op, input logic [4:0] rs, rt,
                                     input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // reference model written from the requirements
  task automatic model(input logic [31:0] ins, a, b, output logic v,
                       output logic [31:0] r, output logic [4:0] d, output logic o);
    logic [5:0]  op, fn;
    logic [4:0]  sh;
    logic [31:0] sx, zx;
    op = ins[31:26]; fn = ins[5:0]; sh = ins[10:6];
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'h0000, ins[15:0]};
    v = 1'b1; r = '0; o = 1'b0;
    d = (op == 6'h00) ? ins[15:11] : ins[20:16];
    if (op == 6'h00) begin
      case (fn)
        6'h00: begin v = (ins[25:21] == 5'd0); r = b << sh; end
        6'h02: begin v = (ins[25:21] == 5'd0); r = b >> sh; end
        6'h03: begin v = (ins[25:21] == 5'd0); r = $signed(b) >>> sh; end
        6'h04: r = b << a[4:0];
        6'h06: r = b >> a[4:0];
        6'h07: r = $signed(b) >>> a[4:0];
        6'h20: begin r = a + b; o = (a[31] == b[31]) && (r[31] != a[31]); end
        6'h21: r = a + b;
        6'h22: begin r = a - b; o = (a[31] != b[31]) && (r[31] != a[31]); end
        6'h23: r = a - b;
        6'h24: r = a & b;
        6'h25: r = a | b;
        6'h26: r = a ^ b;
        6'h27: r = ~(a | b);
        6'h2A: r = {31'd0, $signed(a) < $signed(b)};
        6'h2B: r = {31'd0, a < b};
        default: v = 1'b0;
      endcase
    end else begin
      case (op)
        6'h08: begin r = a + sx; o = (a[31] == sx[31]) && (r[31] != a[31]); end
        6'h09: r = a + sx;
        6'h0A: r = {31'd0, $signed(a) < $signed(sx)};
        6'h0B: r = {31'd0, a < sx};
        6'h0C: r = a & zx;
        6'h0D: r = a | zx;
        6'h0E: r = a ^ zx;
        6'h0F: r = {ins[15:0], 16'h0000};
        default: v = 1'b0;
      endcase
    end
    if (!v) begin r = '0; o = 1'b0; end
  endtask

  task automatic chk(input logic [31:0] ins, a, b, input string tag);
    logic        v, o, w;
    logic [31:0] r;
    logic [4:0]  d;
    model(ins, a, b, v, r, d, o);
    w = v && (d != 5'd0);
    @(posedge clk);
    instr = ins; rs_val = a; rt_val = b;
    @(negedge clk);
    n_chk++;
    if (wr_en !== w || ovf !== o || result !== r || (v && dest !== d)) begin
      n_fail++;
      $display("FAIL %s ins=%h res=%h exp=%h dest=%0d exp=%0d wr=%b exp=%b ovf=%b exp=%b",
               tag, ins, result, r, dest, d, wr_en, w, ovf, o);
    end
  endtask

  function automatic string tag_fn(input logic [5:0] fn);
    case (fn)
      6'h20, 6'h21, 6'h22, 6'h23: return "R1";
      6'h24, 6'h25, 6'h26, 6'h27: return "R2";
      6'h2A, 6'h2B: return "R3";
      6'h00, 6'h02, 6'h03: return "R4";
      6'h04, 6'h06, 6'h07: return "R5";
      default: return "R11";
    endcase
  endfunction

  function automatic string tag_op(input logic [5:0] op);
    case (op)
      6'h08, 6'h09, 6'h0A, 6'h0B: return "R6";
      6'h0C, 6'h0D, 6'h0E: return "R7";
      6'h0F: return "R8";
      default: return "R11";
    endcase
  endfunction

  localparam logic [31:0] PA [12] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
    32'h80000000, 32'hFFFFFFFF, 32'h12345678, 32'hFFFFFFEC, 32'h7FFFFFFF,
    32'h00000005, 32'hFFFFFFFF, 32'h80000001};
  localparam logic [31:0] PB [12] = '{32'h0, 32'h1, 32'h00000001, 32'hFFFFFFFF,
    32'h00000001, 32'hFFFFFFFF, 32'h9ABCDEF0, 32'h00000014, 32'hFFFFFFFF,
    32'h00000005, 32'h00000001, 32'h7FFFFFFF};
  localparam logic [5:0] RFN [16] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25,
    6'h26, 6'h27, 6'h2A, 6'h2B, 6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07};
  localparam logic [15:0] IMS [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
    16'hFFFD, 16'hFFFF, 16'h00FF, 16'h5A5A};

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired before all checks R1 to R12 ran");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // idle word: sll to register 0 must not write (R12)
    chk(32'h0, 32'h0, 32'h0, "R12 idle");

    // register-format operations over fixed and random operand pairs
    for (int f = 0; f < 16; f++) begin
      for (int k = 0; k < 20; k++) begin
        logic [31:0] a, b, r1;
        a = (k < 12) ? PA[k] : rnd();
        b = (k < 12) ? PB[k] : rnd();
        r1 = rnd();
        chk(rw((RFN[f] <= 6'h03) ? 5'd0 : r1[4:0], r1[9:5], r1[14:10] | 5'd1,
               r1[19:15], RFN[f]), a, b, tag_fn(RFN[f]));
      end
    end

    // fixed-amount shifts, every amount (R4)
    for (int s = 0; s < 32; s++) begin
      chk(rw(5'd0, 5'd3, 5'd4, 5'(s), 6'h00), rnd(), 32'h8000F00F, "R4 sll");
      chk(rw(5'd0, 5'd3, 5'd4, 5'(s), 6'h02), rnd(), 32'h8000F00F, "R4 srl");
      chk(rw(5'd0, 5'd3, 5'd4, 5'(s), 6'h03), rnd(), 32'h8000F00F, "R4 sra");
      chk(rw(5'd0, 5'd3, 5'd4, 5'(s), 6'h03), rnd(), 32'h7000F00F, "R4 sra pos");
    end
    chk(rw(5'd0, 5'd3, 5'd4, 5'd1, 6'h03), 32'h0, 32'hFFFFFFEC, "R4 sra -20");
    chk(rw(5'd7, 5'd3, 5'd4, 5'd1, 6'h00), 32'h0, 32'h1, "R4 rs field nonzero");

    // variable shifts with junk in the upper amount bits (R5)
    for (int s = 0; s < 32; s++) begin
      logic [31:0] j;
      j = rnd();
      chk(rw(5'd2, 5'd3, 5'd4, 5'd9, 6'h04), {j[31:5], 5'(s)}, 32'h8000F00F, "R5 sllv");
      chk(rw(5'd2, 5'd3, 5'd4, 5'd9, 6'h06), {j[31:5], 5'(s)}, 32'h8000F00F, "R5 srlv");
      chk(rw(5'd2, 5'd3, 5'd4, 5'd9, 6'h07), {j[31:5], 5'(s)}, 32'h8000F00F, "R5 srav");
    end

    // immediate operations (R6 R7 R8)
    for (int op = 8; op < 16; op++) begin
      for (int k = 0; k < 12; k++) begin
        logic [31:0] r1;
        r1 = rnd();
        chk(iw(6'(op), r1[4:0], r1[9:5] | 5'd1, (k < 8) ? IMS[k] : r1[31:16]),
            PA[k], rnd(), tag_op(6'(op)));
      end
    end
    chk(iw(6'h08, 5'd11, 5'd9, 16'hFFFD), 32'd10, 32'h0, "R6 addi -3");
    chk(iw(6'h0B, 5'd1, 5'd2, 16'hFFFF), 32'hFFFFFFFE, 32'h0, "R6 sltiu sign-extended");
    chk(iw(6'h0C, 5'd1, 5'd2, 16'h8001), 32'hFFFFFFFF, 32'h0, "R7 andi zero-extended");

    // destination selection (R9)
    chk(rw(5'd1, 5'd9, 5'd5, 5'd0, 6'h20), 32'd3, 32'd4, "R9 rd");
    chk(iw(6'h09, 5'd1, 5'd9, 16'h0004), 32'd3, 32'd4, "R9 rt");

    // overflow together with write, and with a write to register 0 (R10 R12)
    chk(rw(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'h7FFFFFFF, 32'h1, "R10 add ovf");
    chk(rw(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'h80000000, 32'hFFFFFFFF, "R10 add neg ovf");
    chk(rw(5'd1, 5'd2, 5'd3, 5'd0, 6'h22), 32'h80000000, 32'h1, "R10 sub ovf");
    chk(rw(5'd1, 5'd2, 5'd3, 5'd0, 6'h21), 32'h7FFFFFFF, 32'h1, "R10 addu no flag");
    chk(rw(5'd1, 5'd2, 5'd3, 5'd0, 6'h23), 32'h80000000, 32'h1, "R10 subu no flag");
    chk(iw(6'h08, 5'd1, 5'd2, 16'h0001), 32'h7FFFFFFF, 32'h0, "R10 addi ovf");
    chk(iw(6'h09, 5'd1, 5'd2, 16'h0001), 32'h7FFFFFFF, 32'h0, "R10 addiu no flag");
    chk(rw(5'd1, 5'd2, 5'd0, 5'd0, 6'h20), 32'h7FFFFFFF, 32'h1, "R12 ovf to r0");
    chk(iw(6'h08, 5'd1, 5'd0, 16'h0001), 32'h7FFFFFFF, 32'h0, "R12 addi to r0");

    // sweep every func and every opcode (R11)
    for (int f = 0; f < 64; f++)
      chk(rw(5'd0, 5'd2, 5'd3, 5'd1, 6'(f)), 32'h7FFFFFFF, 32'h1, tag_fn(6'(f)));
    for (int op = 1; op < 64; op++)
      chk(iw(6'(op), 5'd1, 5'd2, 16'h0001), 32'h7FFFFFFF, 32'h0, tag_op(6'(op)));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule